// File: doc/BRIEF.md
# I2C Wiper Position Target

This block is an I2C target that holds one 7-bit wiper code for a 128-step resistor ladder and drives that code straight to the analog stage. The controller's SCL and SDA lines reach the block through two-flop synchronizers and a short glitch filter, all clocked by a fast system clock. The block pulls SDA low through an open-drain enable and never drives it high. A strap input picks one of two fixed 7-bit target addresses, so two of these blocks can share one bus.

A write is made of three bytes: the address with the direction bit clear, a command byte that must be zero, and a data byte. The most significant bit of the data byte is dropped. The code can be read back in two ways. The first is a combined transfer: command byte, repeated START, then the address with the direction bit set. The second is a short read that sends the read address alone, with no command byte. The block has no timeout and no clock stretching. The wiper code returns to mid-scale on reset.

Top module: `dpot_i2c_target`

## Requirements
- R1: While reset is high and in the cycle after it falls, `wiper` is 0x40 and `sda_oe` is 0.
- R2: The target answers only to 7-bit address 0x2E when `addr_sel` is 0 and only to 0x3E when it is 1. The address sits in bits 7:1 of the first byte and bit 0 is the direction (0 = write). An address that does not match gets no acknowledge (SDA stays high on the ninth clock), and the block leaves SDA alone until the next START or STOP.
- R3: After address(write), ACK, command 0x00, ACK and a data byte, the target acknowledges the data byte and `wiper` takes data bits 6:0. Bit 7 is dropped, so 0xFF gives 0x7F and 0x80 gives 0x00.
- R4: A command byte other than 0x00 is not acknowledged, and data that follows it leaves `wiper` unchanged.
- R5: In a write, data bytes after the first are acknowledged but do not change `wiper`.
- R6: A combined read (address(write), command 0x00, repeated START, address(read)) returns the byte {0, wiper[6:0]}, MSB first.
- R7: A short read (START, address(read)) with no command byte returns the same byte {0, wiper[6:0]}.
- R8: While the controller acknowledges read bytes, the target sends the same byte again. It releases SDA during every acknowledge bit. After a NACK it no longer drives SDA.
- R9: A START seen at any point, including partway through a byte, drops the current transfer without changing `wiper`, and address reception starts again from the first bit.
- R10: A pulse on SCL shorter than the filter length (FILT_CYCLES system clocks, default 3) is ignored and does not count as a bit.
- R11: The target begins pulling SDA low only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level (the resolved bus) |
| addr_sel | input | 1 | Address strap: 0 selects 0x2E, 1 selects 0x3E |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| wiper | output | 7 | Wiper code to the analog ladder |

## Verification
A wrong internal state shows up at the ports within one byte. A bad acknowledge decision puts the wrong level on SDA at the ninth clock of the same byte. A miscounted bit moves the acknowledge slot, or shifts the read byte by one place, within that byte. A bad write path shows up on `wiper` a few system clocks after the data byte's eighth SCL falling edge. A state machine that does not return to idle shows up as SDA held low after a NACK or a STOP, or as an acknowledge given to a foreign address in the next transfer.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam logic [6:0] ADDR_STRAP0 = 7'h2E;
  localparam logic [6:0] ADDR_STRAP1 = 7'h3E;
  localparam logic [7:0] CMD_WIPER   = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_READ,
    ST_IGNORE
  } dpot_state_e;
endpackage

// File: rtl/dpot_line_filter.sv
module dpot_line_filter #(
  parameter int STAGES      = 2,
  parameter int FILT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [STAGES-1:0] sync_q;
  logic [CW-1:0]     run_q;
  logic              clean_q;

  // Synchronizer chain, then the output flips only after a stable run.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      run_q   <= '0;
      clean_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], raw_i};
      if (sync_q[STAGES-1] != clean_q) begin
        if (run_q == CW'(FILT_CYCLES - 1)) begin
          clean_q <= ~clean_q;
          run_q   <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign clean_o = clean_q;
endmodule

// File: rtl/dpot_wiper_reg.sv
module dpot_wiper_reg #(
  parameter int              WIDTH      = 7,
  parameter logic [WIDTH-1:0] RESET_CODE = 7'h40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RESET_CODE;
    else if (we) q <= din;
  end
endmodule

// File: rtl/dpot_i2c_target.sv
module dpot_i2c_target
  import dpot_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter int              FILT_CYCLES = 3,
  parameter int              WIPER_W     = 7,
  parameter logic [WIPER_W-1:0] RESET_CODE = 7'h40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               addr_sel,
  output logic               sda_oe,
  output logic [WIPER_W-1:0] wiper
);
  localparam int BYTE_W = WIPER_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  // Line conditioning, one filter per bus line: index 0 = SCL, 1 = SDA
  logic [1:0] raw_v, clean_v;
  assign raw_v = {sda_i, scl_i};
  for (genvar i = 0; i < 2; i++) begin : g_line
    dpot_line_filter #(.STAGES(SYNC_STAGES), .FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk(clk), .rst(rst), .raw_i(raw_v[i]), .clean_o(clean_v[i])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = clean_v[0];
  assign sda_f = clean_v[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  // Transfer state
  dpot_state_e       state, nxt_st, next_now;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg, rd_byte;
  logic              in_ack, oe_q, first_data, nack_seen, ack_now, wr_en;
  logic [6:0]        own_addr;

  assign own_addr = addr_sel ? ADDR_STRAP1 : ADDR_STRAP0;
  assign rd_byte  = {1'b0, wiper};

  always_comb begin
    ack_now  = 1'b0;
    next_now = ST_IGNORE;
    case (state)
      ST_ADDR: if (shreg[BYTE_W-1:1] == own_addr) begin
        ack_now  = 1'b1;
        next_now = shreg[0] ? ST_READ : ST_CMD;
      end
      ST_CMD: if (shreg == CMD_WIPER) begin
        ack_now  = 1'b1;
        next_now = ST_WDATA;
      end
      ST_WDATA: begin
        ack_now  = 1'b1;
        next_now = ST_WDATA;
      end
      default: ;
    endcase
  end

  assign wr_en = (state == ST_WDATA) && scl_fall && !in_ack &&
                 (bit_cnt == LAST_BIT) && first_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      nxt_st     <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      in_ack     <= 1'b0;
      oe_q       <= 1'b0;
      first_data <= 1'b1;
      nack_seen  <= 1'b0;
    end else if (start_det) begin
      state      <= ST_ADDR;
      bit_cnt    <= '0;
      in_ack     <= 1'b0;
      oe_q       <= 1'b0;
      first_data <= 1'b1;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (scl_rise && !in_ack && bit_cnt < LAST_BIT) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && !in_ack && bit_cnt == LAST_BIT) begin
            in_ack <= 1'b1;
            oe_q   <= ack_now;
            nxt_st <= next_now;
            if (state == ST_WDATA) first_data <= 1'b0;
          end else if (scl_fall && in_ack) begin
            in_ack  <= 1'b0;
            bit_cnt <= '0;
            state   <= nxt_st;
            if (nxt_st == ST_READ) begin
              shreg <= rd_byte;
              oe_q  <= ~rd_byte[BYTE_W-1];
            end else begin
              oe_q <= 1'b0;
            end
          end
        end
        ST_READ: begin
          if (scl_rise && !in_ack) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_rise && in_ack) begin
            nack_seen <= sda_f;
          end else if (scl_fall && !in_ack && bit_cnt == LAST_BIT) begin
            oe_q   <= 1'b0;
            in_ack <= 1'b1;
          end else if (scl_fall && !in_ack && bit_cnt != '0) begin
            shreg <= shreg << 1;
            oe_q  <= ~shreg[BYTE_W-2];
          end else if (scl_fall && in_ack) begin
            in_ack  <= 1'b0;
            bit_cnt <= '0;
            if (nack_seen) begin
              state <= ST_IGNORE;
              oe_q  <= 1'b0;
            end else begin
              shreg <= rd_byte;
              oe_q  <= ~rd_byte[BYTE_W-1];
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;

  dpot_wiper_reg #(.WIDTH(WIPER_W), .RESET_CODE(RESET_CODE)) u_wiper (
    .clk(clk), .rst(rst), .we(wr_en), .din(shreg[WIPER_W-1:0]), .q(wiper)
  );
endmodule

// File: rtl/dpot_i2c_target_chk.sv
module dpot_i2c_target_chk
  import dpot_pkg::*;
#(
  parameter int WIPER_W = 7,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               sda_oe,
  input logic [WIPER_W-1:0] wiper,
  input dpot_state_e        state,
  input logic               in_ack,
  input logic               first_data,
  input logic               start_det,
  input logic               scl_f,
  input logic [CNT_W-1:0]   bit_cnt
);
  // R1: reset state visible in the cycle after reset was sampled high
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (wiper == WIPER_W'(7'h40) && !sda_oe));

  // R2: a target that has given up on a transfer stays off the bus
  a_r2_ignore_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe);

  // R4 and R5: the wiper only moves on the first data byte of a write
  a_r4_single_update: assert property (@(posedge clk) disable iff (rst)
    !$stable(wiper) |-> ($past(state) == ST_WDATA && $past(first_data)));

  // R8: during the controller's acknowledge bit of a read the line is released
  a_r8_release_for_ack: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ && in_ack) |-> !sda_oe);

  // R9: a START always restarts address reception from bit zero
  a_r9_start_restarts: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR && bit_cnt == '0 && !sda_oe));

  // R11: the pull-down is only switched on while SCL is low
  a_r11_drive_on_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_f));
endmodule

bind dpot_i2c_target dpot_i2c_target_chk #(.WIPER_W(WIPER_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .wiper(wiper), .state(state),
  .in_ack(in_ack), .first_data(first_data), .start_det(start_det),
  .scl_f(scl_f), .bit_cnt(bit_cnt)
);

// File: tb/dpot_i2c_target_test.sv
module dpot_i2c_target_test;
  localparam int T = 10;  // quarter SCL period in system clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       addr_sel = 1'b0;
  logic       sda_oe;
  logic [6:0] wiper;
  wire        sda_bus;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [6:0] model = 7'h40;

  assign sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  dpot_i2c_target uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .wiper(wiper)
  );

  function automatic logic [6:0] exp_addr(input logic sel);
    return sel ? 7'h3E : 7'h2E;
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [6:0] w);
    return {1'b0, w};
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wt(T);
    scl_m = 1'b1; wt(T);
    sda_m = 1'b0; wt(T);
    scl_m = 1'b0; wt(T);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(T);
    scl_m = 1'b1; wt(T);
    sda_m = 1'b1; wt(T);
  endtask

  task automatic send_bit(input logic b, input logic glitch);
    sda_m = b; wt(T / 2);
    if (glitch) begin
      scl_m = 1'b1; wt(1);
      scl_m = 1'b0;
    end
    wt(T - T / 2);
    scl_m = 1'b1; wt(2 * T);
    scl_m = 1'b0; wt(T);
  endtask

  task automatic get_ack(output logic ack);
    sda_m = 1'b1; wt(T);
    scl_m = 1'b1; wt(T);
    ack = ~sda_bus; wt(T);
    scl_m = 1'b0; wt(T);
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch_bit == i);
    get_ack(ack);
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wt(T);
      scl_m = 1'b1; wt(T);
      d = {d[6:0], sda_bus}; wt(T);
      scl_m = 1'b0; wt(T);
    end
    send_bit(nack, 1'b0);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d,
                          output logic k0, output logic k1, output logic k2);
    i2c_start();
    send_byte({a, 1'b0}, -1, k0);
    send_byte(cmd, -1, k1);
    send_byte(d, -1, k2);
    i2c_stop();
  endtask

  task automatic combined_read(input logic [6:0] a, output logic [7:0] d);
    logic k;
    i2c_start();
    send_byte({a, 1'b0}, -1, k);
    send_byte(8'h00, -1, k);
    i2c_start();
    send_byte({a, 1'b1}, -1, k);
    read_byte(1'b1, d);
    i2c_stop();
  endtask

  task automatic short_read(input logic [6:0] a, output logic ack, output logic [7:0] d);
    i2c_start();
    send_byte({a, 1'b1}, -1, ack);
    read_byte(1'b1, d);
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic k0, k1, k2, k3;
    logic [7:0] d, d2, d3, v;
    int seed;
    seed = $urandom(32'd20241);

    wt(6);
    check("R1 wiper in reset", {1'b0, wiper}, 8'h40);
    check("R1 oe in reset", {7'd0, sda_oe}, 8'h00);
    rst = 1'b0;
    wt(1);
    check("R1 wiper after reset", {1'b0, wiper}, 8'h40);
    wt(20);

    // R3 basic write
    do_write(exp_addr(0), 8'h00, 8'h15, k0, k1, k2);
    model = 7'h15;
    check("R2 addr ack strap0", {7'd0, k0}, 8'h01);
    check("R3 cmd ack", {7'd0, k1}, 8'h01);
    check("R3 data ack", {7'd0, k2}, 8'h01);
    check("R3 wiper 0x15", {1'b0, wiper}, exp_rdata(model));

    // R3 msb dropped
    do_write(exp_addr(0), 8'h00, 8'hFF, k0, k1, k2);
    check("R3 0xFF gives 0x7F", {1'b0, wiper}, 8'h7F);
    do_write(exp_addr(0), 8'h00, 8'h80, k0, k1, k2);
    model = 7'h00;
    check("R3 0x80 gives 0x00", {1'b0, wiper}, 8'h00);

    // R2 foreign address
    do_write(exp_addr(1), 8'h00, 8'h33, k0, k1, k2);
    check("R2 foreign addr nack", {7'd0, k0}, 8'h00);
    check("R2 foreign data nack", {7'd0, k2}, 8'h00);
    check("R2 foreign no change", {1'b0, wiper}, exp_rdata(model));

    // R2 other strap
    addr_sel = 1'b1; wt(4);
    do_write(exp_addr(1), 8'h00, 8'h2A, k0, k1, k2);
    model = 7'h2A;
    check("R2 addr ack strap1", {7'd0, k0}, 8'h01);
    check("R2 write strap1", {1'b0, wiper}, exp_rdata(model));
    do_write(exp_addr(0), 8'h00, 8'h11, k0, k1, k2);
    check("R2 0x2E ignored on strap1", {7'd0, k0}, 8'h00);
    check("R2 no change strap1", {1'b0, wiper}, exp_rdata(model));

    // R4 bad command
    do_write(exp_addr(1), 8'h01, 8'h55, k0, k1, k2);
    check("R4 bad cmd nack", {7'd0, k1}, 8'h00);
    check("R4 no change", {1'b0, wiper}, exp_rdata(model));

    // R5 extra data bytes
    i2c_start();
    send_byte({exp_addr(1), 1'b0}, -1, k0);
    send_byte(8'h00, -1, k1);
    send_byte(8'h61, -1, k2);
    send_byte(8'h12, -1, k3);
    check("R5 extra byte ack", {7'd0, k3}, 8'h01);
    send_byte(8'h13, -1, k3);
    i2c_stop();
    model = 7'h61;
    check("R5 first byte only", {1'b0, wiper}, exp_rdata(model));

    // R6 combined read
    combined_read(exp_addr(1), d);
    check("R6 combined read", d, exp_rdata(model));

    // R7 short read
    short_read(exp_addr(1), k0, d);
    check("R7 short read ack", {7'd0, k0}, 8'h01);
    check("R7 short read data", d, exp_rdata(model));

    // R8 repeated read bytes then NACK
    i2c_start();
    send_byte({exp_addr(1), 1'b1}, -1, k0);
    read_byte(1'b0, d);
    read_byte(1'b0, d2);
    read_byte(1'b1, d3);
    wt(T);
    check("R8 released after nack", {7'd0, sda_oe}, 8'h00);
    i2c_stop();
    check("R8 byte1", d, exp_rdata(model));
    check("R8 byte2", d2, exp_rdata(model));
    check("R8 byte3", d3, exp_rdata(model));
    check("R8 idle after stop", {7'd0, sda_oe}, 8'h00);

    // R9 START partway through the data byte
    i2c_start();
    send_byte({exp_addr(1), 1'b0}, -1, k0);
    send_byte(8'h00, -1, k1);
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
    i2c_start();
    check("R9 partial byte ignored", {1'b0, wiper}, exp_rdata(model));
    send_byte({exp_addr(1), 1'b0}, -1, k0);
    send_byte(8'h00, -1, k1);
    send_byte(8'h0C, -1, k2);
    i2c_stop();
    model = 7'h0C;
    check("R9 restart addr ack", {7'd0, k0}, 8'h01);
    check("R9 write after restart", {1'b0, wiper}, exp_rdata(model));

    // R10 short SCL glitch during the data byte
    i2c_start();
    send_byte({exp_addr(1), 1'b0}, -1, k0);
    send_byte(8'h00, -1, k1);
    send_byte(8'h5A, 4, k2);
    i2c_stop();
    model = 7'h5A;
    check("R10 glitch ignored ack", {7'd0, k2}, 8'h01);
    check("R10 glitch ignored data", {1'b0, wiper}, exp_rdata(model));

    // Random mix: R3 writes, R6 and R7 reads
    for (int it = 0; it < 24; it++) begin
      int op;
      v  = 8'($urandom);
      op = int'($urandom % 3);
      if (op == 0) begin
        do_write(exp_addr(1), 8'h00, v, k0, k1, k2);
        model = v[6:0];
        check("R3 random write", {1'b0, wiper}, exp_rdata(model));
      end else if (op == 1) begin
        combined_read(exp_addr(1), d);
        check("R6 random combined read", d, exp_rdata(model));
      end else begin
        short_read(exp_addr(1), k0, d);
        check("R7 random short read", d, exp_rdata(model));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule